// File: doc/BRIEF.md
# Iterative Fibonacci Calculator

This block returns the Fibonacci number of a small unsigned index. A controller steps a small datapath one term per clock. The datapath has two working registers, which hold the latest two terms, and a countdown of the steps still to do. A client waits for `ready`, presents an index, and pulses `start`. Some cycles later `done` rises for exactly one clock. From that cycle on, `result` carries the answer and keeps it until the next accepted request.

The controller has three states:

- **IDLE** asserts `ready`. On `start` it loads the working terms with 0 and 1, loads the countdown with the index, and moves to **STEP**.
- **STEP** acts on the countdown value:
  - At zero it forces the newer term to 0 and moves to **DONE**.
  - At one it moves to **DONE** with the newer term left as it is.
  - Otherwise it replaces the newer term by the sum of both terms, moves the old newer term into the older one, and decrements the countdown. All three updates happen on the same edge, and the state stays in **STEP**.
- **DONE** pulses `done` and always returns to **IDLE**.

An index of i therefore reaches DONE max(i,1) clocks after the accepting edge. That is i-1 summing cycles plus the final decision cycle.

Top module: `fib_calc`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `result` is 0. All working registers are cleared and the controller is in IDLE.
- R2: `ready` is 1 only in IDLE. It drops on the edge that accepts `start` and stays 0 until the edge after the `done` cycle.
- R3: An index of 0 gives a result of 0, even when the previous result was non-zero.
- R4: An index of 1 gives a result of 1.
- R5: An index i of 2 or more gives F(i), where F(0)=0, F(1)=1 and F(k)=F(k-1)+F(k-2). This relies on both working terms being updated together on each summing edge.
- R6: `done` is high for exactly one clock. It appears max(i,1) clocks after the edge that accepted `start`, and `ready` returns on the following edge.
- R7: `start` and `index` are ignored while `ready` is 0. Neither the answer nor the timing of the running request changes.
- R8: While IDLE and not started, `result` holds the last answer whatever `index` does.
- R9: The result is 21 bits wide, so the largest index, 31, yields 1346269 exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Request pulse, accepted only while `ready` is 1 |
| index | input | 5 | Index of the Fibonacci number wanted |
| ready | output | 1 | Block is idle and can accept a request |
| done | output | 1 | One-clock pulse: result is valid |
| result | output | 21 | Newer working term; the answer after `done` |

## Verification
The `done` cycle and a fresh `start` can fall together, and so can the first idle cycle and a repeated `start`. The bench holds `start` high across a whole computation and through its completion. It checks three things: the `done` pulse stays one clock wide, the second request is taken only once `ready` is back, and the second `done` lands exactly its own latency later. A further test pulses `start` with a new index in the middle of a run. It then checks that the running answer and its timing are unchanged.

// File: rtl/fib_pkg.sv
package fib_pkg;
    parameter int IDX_W = 5;
    parameter int RES_W = 21;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } fib_state_t;
endpackage

// File: rtl/fib_ctrl.sv
module fib_ctrl
    import fib_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic ready,
    output logic done,
    output logic load,
    output logic step,
    output logic clear
);
    fib_state_t state, state_nx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        ready    = 1'b0;
        done     = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        clear    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                if (start) begin
                    load     = 1'b1;
                    state_nx = ST_STEP;
                end
            end
            ST_STEP: begin
                if (cnt_zero) begin
                    clear    = 1'b1;
                    state_nx = ST_DONE;
                end else if (cnt_one) begin
                    state_nx = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_DONE: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fib_datapath.sv
module fib_datapath #(
    parameter int IDX_W = 5,
    parameter int RES_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             clear,
    input  logic [IDX_W-1:0] index,
    output logic             cnt_zero,
    output logic             cnt_one,
    output logic [RES_W-1:0] newer
);
    localparam logic [IDX_W-1:0] CNT_ONE = IDX_W'(1);

    logic [RES_W-1:0] older_q, newer_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            older_q <= '0;
            newer_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            older_q <= '0;
            newer_q <= RES_W'(1);
            cnt_q   <= index;
        end else if (clear) begin
            newer_q <= '0;
        end else if (step) begin
            newer_q <= newer_q + older_q;
            older_q <= newer_q;
            cnt_q   <= cnt_q - CNT_ONE;
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_ONE);
    assign newer    = newer_q;
endmodule

// File: rtl/fib_calc.sv
module fib_calc
    import fib_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int RW = RES_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] index,
    output logic          ready,
    output logic          done,
    output logic [RW-1:0] result
);
    logic load, step, clear, cnt_zero, cnt_one;

    fib_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .ready    (ready),
        .done     (done),
        .load     (load),
        .step     (step),
        .clear    (clear)
    );

    fib_datapath #(.IDX_W(IW), .RES_W(RW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .clear    (clear),
        .index    (index),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .newer    (result)
    );
endmodule

// File: rtl/fib_calc_chk.sv
module fib_calc_chk #(
    parameter int IW = 5,
    parameter int RW = 21
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [IW-1:0] index,
    input logic          ready,
    input logic          done,
    input logic [RW-1:0] result
);
    logic [IW-1:0] taken_idx;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)                taken_idx <= '0;
        else if (ready && start) taken_idx <= index;
    end

    // R2
    a_r2_ready_not_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready);
    // R2
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready);
    // R6
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6
    a_r6_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);
    // R8
    a_r8_result_held_idle: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> $stable(result));
    // R3
    a_r3_zero_index: assert property (@(posedge clk) disable iff (rst)
        (done && taken_idx == '0) |-> result == '0);
    // R4
    a_r4_one_index: assert property (@(posedge clk) disable iff (rst)
        (done && taken_idx == IW'(1)) |-> result == RW'(1));
endmodule

bind fib_calc fib_calc_chk #(.IW(IW), .RW(RW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .index  (index),
    .ready  (ready),
    .done   (done),
    .result (result)
);

// File: tb/fib_calc_test.sv
`timescale 1ns/1ps
module fib_calc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  index = '0;
    logic        ready, done;
    logic [20:0] result;
    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    fib_calc uut (
        .clk(clk), .rst(rst), .start(start), .index(index),
        .ready(ready), .done(done), .result(result)
    );

    function automatic longint fib_ref(input int k);
        longint a = 0;
        longint b = 1;
        if (k == 0) return 0;
        for (int j = 1; j < k; j++) begin
            longint t = a + b;
            a = b;
            b = t;
        end
        return b;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns number of negedges after the accepting edge until done seen
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 80) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("watchdog", 0, 1);
    endtask

    task automatic run_one(input string req, input int k);
        int cyc;
        int lat;
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1'b1;
        index = 5'(k);
        @(negedge clk);
        start = 1'b0;
        chk({req, " R2 ready low after accept"}, ready, 0);
        wait_done(cyc);
        lat = (k < 1) ? 1 : k;
        chk({req, " R6 latency"}, cyc, lat);
        chk({req, " value"}, result, fib_ref(k));
        @(negedge clk);
        chk({req, " R6 done one cycle"}, done, 0);
        chk({req, " R6 ready back"}, ready, 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 ready", ready, 1);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
    endtask

    task automatic test_busy_start();
        int cyc;
        @(negedge clk);
        start = 1'b1;
        index = 5'd10;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        index = 5'd3;
        @(negedge clk);
        start = 1'b0;
        index = 5'd0;
        cyc = 4;
        while (!done && cyc < 80) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7 latency unchanged", cyc, 10);
        chk("R7 value unchanged", result, fib_ref(10));
        @(negedge clk);
        chk("R7 ready back", ready, 1);
    endtask

    task automatic test_hold();
        longint keep = result;
        for (int k = 0; k < 16; k++) begin
            index = 5'(k * 3);
            @(negedge clk);
            chk("R8 result held", result, keep);
        end
    endtask

    task automatic test_start_held();
        int cyc;
        @(negedge clk);
        start = 1'b1;
        index = 5'd4;
        @(negedge clk);
        wait_done(cyc);
        chk("R6 held start first latency", cyc, 4);
        chk("R5 held start first value", result, fib_ref(4));
        @(negedge clk);
        chk("R6 held start single done", done, 0);
        chk("R2 held start ready idle", ready, 1);
        index = 5'd6;
        @(negedge clk);
        start = 1'b0;
        chk("R2 held start reaccepted", ready, 0);
        wait_done(cyc);
        chk("R6 held start second latency", cyc, 6);
        chk("R5 held start second value", result, fib_ref(6));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        run_one("R4 index1", 1);
        run_one("R3 index0", 0);
        run_one("R5 index2", 2);
        run_one("R5 index5", 5);
        run_one("R3 index0 after nonzero", 0);
        run_one("R5 index10", 10);
        run_one("R9 index31", 31);
        test_hold();
        test_busy_start();
        test_start_held();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #500000;
        fails++;
        total++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule